// File: doc/BRIEF.md
# TDM audio frame deserializer

This block receives time-division-multiplexed PCM audio and turns each frame into eight parallel signed 24-bit samples. The bit clock is the block's clock, and serial data is sampled on its rising edge. A frame-sync input rises once per frame, and that rising edge marks the start of a frame. Two framings are supported. In the 256-clock framing, all eight channels arrive one after another on data line 0. In the 128-clock framing, channels 0 to 3 arrive on line 0 and channels 4 to 7 on line 1, at the same time.

Each channel takes a 32-bit slot. The slot carries a two's-complement sample MSB first, in its upper 24 bit times, followed by 8 pad bits. When a frame closes with exactly the right number of bit clocks, the block publishes all eight samples together with a one-cycle strobe. A frame of any other length is dropped. Counting always restarts at the next frame-sync rise, so the block resynchronizes there.

Top module: `tdm_deser`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `smp_valid` is 0 and `smp_data` is all zeros.
- R2: With `mode128` = 0 at frame start, slot k (k = 0..7) of line 0 (`sdin[0]`) is delivered as channel k, at bits [24k+23:24k] of `smp_data`.
- R3: With `mode128` = 1 at frame start, slots 0..3 of line 0 become channels 0..3, and slots 0..3 of line 1 (`sdin[1]`) become channels 4..7.
- R4: Within a 32-bit slot, the first 24 bits form the sample MSB first, read as two's complement. The last 8 bits have no effect on the output.
- R5: A frame starts on the clock edge where `fsync` is sampled 1 after being sampled 0. The MSB of slot 0 is sampled on the following edge.
- R6: In the 256-clock framing, line 1 has no effect on `smp_data`.
- R7: A frame of exactly 256 (`mode128` = 0) or 128 (`mode128` = 1) bit clocks, ended by the next frame start, gives one single-cycle `smp_valid` pulse. The pulse is visible in the cycle after that start edge, together with the new `smp_data`.
- R8: A frame of any other length gives no `smp_valid`, and `smp_data` keeps its previous value. The next correctly sized frame is delivered normally.
- R9: While `tdm_en` is 0, no frame is captured and `smp_valid` stays 0. After `tdm_en` returns to 1, the first frame start only opens a frame and publishes nothing.
- R10: `mode128` is taken at frame start and holds for the whole frame. Changing the input mid-frame has no effect on that frame.
- R11: Between `smp_valid` pulses, `smp_data` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Bit clock. Data and frame sync are sampled on its rising edge. |
| rst_n | input | 1 | Asynchronous active-low reset |
| tdm_en | input | 1 | Enables reception (1 = on) |
| mode128 | input | 1 | Framing select: 0 = 256 clocks on one line, 1 = 128 clocks on two lines |
| fsync | input | 1 | Frame sync. Its rising edge starts a frame. |
| sdin | input | 2 | Serial data lines 0 and 1 |
| smp_valid | output | 1 | One-cycle strobe: a new frame of samples is available |
| smp_data | output | 192 | Eight signed 24-bit samples, channel c at [24c+23:24c] |

## Verification
The edge on which a frame-sync rise is seen also closes the previous frame. On that same edge, the last pad bit of the old frame is sampled, the length check is judged, and the framing select for the new frame is latched.

The bench provokes this coincidence in three ways:
- It runs frames back to back.
- It changes the framing between consecutive frames.
- It flips `mode128` midway through every frame.

It judges the outcome from the strobe and the sample word one cycle after each start edge:
- The word must match the frame just closed, or keep its old value after a short or long frame or a disabled interval.
- The strobe must be low again on the next cycle.

// File: rtl/tdm_deser_pkg.sv
package tdm_deser_pkg;

  // Slot index (inside one data line) that carries channel ch.
  function automatic int chan_slot(input int ch, input int nch, input logic m128);
    return m128 ? (ch % (nch / 2)) : ch;
  endfunction

  // Data line that carries channel ch.
  function automatic int chan_line(input int ch, input int nch, input logic m128);
    return (m128 && ch >= nch / 2) ? 1 : 0;
  endfunction

  // Index of the last bit in a frame, for the given framing.
  function automatic int frame_last_bit(input int len_full, input logic m128);
    return m128 ? (len_full / 2 - 1) : (len_full - 1);
  endfunction

endpackage

// File: rtl/tdm_frame_ctl.sv
module tdm_frame_ctl
  import tdm_deser_pkg::*;
#(
  parameter int LEN_FULL = 256,
  parameter int CW       = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          mode128,
  input  logic          fsync,
  output logic [CW-1:0] cnt,
  output logic          mode_q,
  output logic          cap_en,
  output logic          frame_start,
  output logic          frame_done
);

  localparam logic [CW-1:0] LAST256 = CW'(frame_last_bit(LEN_FULL, 1'b0));
  localparam logic [CW-1:0] LAST128 = CW'(frame_last_bit(LEN_FULL, 1'b1));

  logic          fs_q;
  logic          active;
  logic [CW-1:0] last_bit;

  assign frame_start = fsync & ~fs_q;
  assign last_bit    = mode_q ? LAST128 : LAST256;
  assign cap_en      = en & active;
  assign frame_done  = en & active & frame_start & (cnt == last_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q   <= 1'b0;
      active <= 1'b0;
      cnt    <= '0;
      mode_q <= 1'b0;
    end else begin
      fs_q <= fsync;
      if (!en) begin
        active <= 1'b0;
        cnt    <= '0;
      end else if (frame_start) begin
        active <= 1'b1;
        cnt    <= '0;
        mode_q <= mode128;
      end else if (active && cnt != '1) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R5
  start_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && frame_start) |=> (cnt == '0));

  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && active && !frame_start && cnt != '1) |=> (cnt == $past(cnt) + 1'b1));

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(mode_q));

endmodule

// File: rtl/tdm_slot_capture.sv
module tdm_slot_capture
  import tdm_deser_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int SW    = 24,
  parameter int SLOTW = 32,
  parameter int CW    = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              mode_q,
  input  logic [CW-1:0]     cnt,
  input  logic [1:0]        sdin,
  output logic [NCH*SW-1:0] asm_data
);

  localparam int SBW = $clog2(SLOTW);
  localparam int SLW = CW - SBW;

  logic [SLW-1:0] cur_slot;
  logic [SBW-1:0] cur_bit;
  logic           data_bit;

  assign cur_slot = cnt[CW-1:SBW];
  assign cur_bit  = cnt[SBW-1:0];
  assign data_bit = (cur_bit < SBW'(SW));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SW-1:0] shreg;
    logic          hit;
    logic          din;

    assign hit = cap_en && data_bit &&
                 (cur_slot == SLW'(chan_slot(c, NCH, mode_q)));
    assign din = sdin[chan_line(c, NCH, mode_q)];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shreg <= '0;
      else if (hit) shreg <= {shreg[SW-2:0], din};
    end

    assign asm_data[c*SW +: SW] = shreg;
  end

endmodule

// File: rtl/tdm_deser.sv
module tdm_deser #(
  parameter int NCH   = 8,
  parameter int SW    = 24,
  parameter int SLOTW = 32
) (
  input  logic              clk_bit,
  input  logic              rst_n,
  input  logic              tdm_en,
  input  logic              mode128,
  input  logic              fsync,
  input  logic [1:0]        sdin,
  output logic              smp_valid,
  output logic [NCH*SW-1:0] smp_data
);

  localparam int LEN_FULL = NCH * SLOTW;
  localparam int CW       = $clog2(LEN_FULL) + 1;

  logic [CW-1:0]     cnt;
  logic              mode_q;
  logic              cap_en;
  logic              frame_start;
  logic              frame_done;
  logic [NCH*SW-1:0] asm_data;

  tdm_frame_ctl #(.LEN_FULL(LEN_FULL), .CW(CW)) u_ctl (
    .clk         (clk_bit),
    .rst_n       (rst_n),
    .en          (tdm_en),
    .mode128     (mode128),
    .fsync       (fsync),
    .cnt         (cnt),
    .mode_q      (mode_q),
    .cap_en      (cap_en),
    .frame_start (frame_start),
    .frame_done  (frame_done)
  );

  tdm_slot_capture #(.NCH(NCH), .SW(SW), .SLOTW(SLOTW), .CW(CW)) u_cap (
    .clk      (clk_bit),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .mode_q   (mode_q),
    .cnt      (cnt),
    .sdin     (sdin),
    .asm_data (asm_data)
  );

  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) begin
      smp_valid <= 1'b0;
      smp_data  <= '0;
    end else begin
      smp_valid <= frame_done;
      if (frame_done) smp_data <= asm_data;
    end
  end

  // R7
  valid_after_start_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    smp_valid |-> $past(frame_start));

  // R7
  valid_single_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    smp_valid |=> !smp_valid);

  // R11
  data_hold_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !smp_valid |-> $stable(smp_data));

  // R9
  idle_no_valid_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !tdm_en |=> !smp_valid);

endmodule

// File: tb/test_tdm_deser.sv
`timescale 1ns/1ps
module test_tdm_deser;

  localparam int NCH = 8;
  localparam int SW  = 24;
  localparam int DW  = NCH * SW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tdm_en = 1'b1;
  logic          mode128 = 1'b0;
  logic          fsync = 1'b0;
  logic [1:0]    sdin = 2'b00;
  logic          smp_valid;
  logic [DW-1:0] smp_data;

  int n_tests = 0;
  int n_fail  = 0;

  logic          pend_ok = 1'b0;
  logic [DW-1:0] pend_data = '0;
  logic [DW-1:0] held = '0;
  string         pend_tag = "R2";

  always #5 clk = ~clk;

  tdm_deser i_tdm_deser (
    .clk_bit(clk), .rst_n(rst_n), .tdm_en(tdm_en), .mode128(mode128),
    .fsync(fsync), .sdin(sdin), .smp_valid(smp_valid), .smp_data(smp_data)
  );

  // Vector fields: {en, m128, kind[1:0], seed[15:0]}.
  // kind: 0 = good, 1 = one bit short, 2 = one bit long, 3 = good with extreme samples.
  localparam logic [19:0] VEC [12] = '{
    {1'b1, 1'b0, 2'd0, 16'h1234},
    {1'b1, 1'b0, 2'd3, 16'h0000},
    {1'b1, 1'b1, 2'd0, 16'h0F0F},
    {1'b1, 1'b1, 2'd1, 16'h2222},
    {1'b1, 1'b1, 2'd0, 16'h004D},
    {1'b1, 1'b0, 2'd2, 16'h3333},
    {1'b1, 1'b0, 2'd0, 16'hBEEF},
    {1'b0, 1'b0, 2'd0, 16'h0005},
    {1'b0, 1'b1, 2'd0, 16'h0006},
    {1'b1, 1'b1, 2'd0, 16'h0063},
    {1'b1, 1'b0, 2'd0, 16'h1357},
    {1'b1, 1'b1, 2'd3, 16'h0000}
  };

  function automatic logic [SW-1:0] smp_of(input logic [15:0] seed, input logic [1:0] kind, input int ch);
    logic [31:0] h;
    if (kind == 2'd3) return (ch % 2 == 0) ? 24'h800000 : 24'h7FFFFF;
    h = {16'h0, seed} * 32'd40503 + 32'h5A3C1 * (ch + 1);
    return h[23:0] ^ {seed[7:0], 16'h0};
  endfunction

  function automatic logic [DW-1:0] build_exp(input logic [15:0] seed, input logic [1:0] kind);
    logic [DW-1:0] v;
    for (int c = 0; c < NCH; c++) v[c*SW +: SW] = smp_of(seed, kind, c);
    return v;
  endfunction

  function automatic logic bitv(input int line, input int p, input logic m128,
                                input logic [15:0] seed, input logic [1:0] kind);
    int slot, b, ch;
    logic [SW-1:0] s;
    slot = p / 32;
    b = p % 32;
    if (!m128 && line == 1) return 1'($urandom);   // R6: line 1 is noise
    if (b >= SW) return 1'b1;                      // R4: pad bits set
    if (m128) begin
      if (slot >= 4) return 1'b1;
      ch = (line == 0) ? slot : 4 + slot;
    end else begin
      if (slot >= 8) return 1'b1;
      ch = slot;
    end
    s = smp_of(seed, kind, ch);
    return s[SW-1-b];
  endfunction

  task automatic check(input logic ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic en, input logic m128, input logic [1:0] kind, input logic [15:0] seed);
    int len;
    logic exp_v;
    logic [DW-1:0] exp_d;
    len = m128 ? 128 : 256;
    if (kind == 2'd1) len--;
    else if (kind == 2'd2) len++;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == 1) begin
        // R5 R7 R8 R9: strobe in the cycle after the start edge
        exp_v = pend_ok && en;
        check(smp_valid == exp_v, "R7 R8 R9 valid after frame start", DW'(smp_valid), DW'(exp_v));
        exp_d = exp_v ? pend_data : held;
        check(smp_data == exp_d, pend_tag, smp_data, exp_d);
        if (exp_v) held = pend_data;
        pend_ok   = en && (kind == 2'd0 || kind == 2'd3);
        pend_data = build_exp(seed, kind);
        pend_tag  = m128 ? "R3 R4 R5 R10 R11 data" : "R2 R4 R5 R6 R10 R11 data";
      end
      if (i == 2) check(smp_valid == 1'b0, "R7 single-cycle valid", DW'(smp_valid), '0);
      if (i == 0) begin
        tdm_en  = en;
        mode128 = m128;
        fsync   = 1'b1;
        sdin    = 2'b11;
      end else begin
        fsync   = (i < len / 2);
        sdin[0] = bitv(0, i - 1, m128, seed, kind);
        sdin[1] = bitv(1, i - 1, m128, seed, kind);
        if (i == len / 2) mode128 = ~m128;   // R10: ignored mid-frame
      end
    end
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(smp_valid == 1'b0 && smp_data == '0, "R1 reset state", smp_data, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(smp_valid == 1'b0 && smp_data == '0, "R1 after release", smp_data, '0);

    for (int k = 0; k < 12; k++)
      send_frame(VEC[k][19], VEC[k][18], VEC[k][17:16], VEC[k][15:0]);
    send_frame(1'b1, 1'b0, 2'd0, 16'h0001);

    // R1: reset in the middle of a frame clears outputs
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(smp_valid == 1'b0 && smp_data == '0, "R1 mid-run reset", smp_data, '0);
    fsync = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    held = '0;
    pend_ok = 1'b0;
    send_frame(1'b1, 1'b1, 2'd0, 16'h0ACE);
    send_frame(1'b1, 1'b0, 2'd0, 16'h7777);
    send_frame(1'b1, 1'b0, 2'd0, 16'h0002);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule